// File: doc/BRIEF.md
# Drift-Aware Memory Scrub Scheduler

This block paces periodic light reads of a multi-level-cell memory whose stored levels slowly drift until they read back wrong. An interval timer counts idle cycles. Each time it expires, the block requests a read of the next line address, walking the lines in order and wrapping at the end. The external ECC decoder answers every read with two counts for that line: corrected errors and hard errors. From these the block decides whether the line needs a scrub, which is a rewrite that resets the drift. It asks for the rewrite only when the corrected count has climbed to a threshold that keeps a headroom below the code's correction limit. Lines that are still healthy are left alone and cost no write.

The block has three policies. A fixed headroom sets the scrub threshold below the correction strength E. An optional gradual mode halves the read interval whenever a checked line comes close to the threshold. An optional adaptive mode adds two things: it drops the headroom to zero once a single line reports many hard errors, and it halves the interval once when the running hard-error total passes a programmed limit. The interval never goes below a programmed minimum. A line whose corrected count is above E cannot be repaired by rewriting, so it raises a fault pulse and a sticky fault flag instead.

Top module: `drift_scrub_scheduler`

## Requirements
- R1: While reset is held, both request valids and the fault outputs are low, `cur_headroom` equals the HEADROOM parameter (default 3), and `cur_interval` equals the larger of `cfg_interval` and the effective minimum. The effective minimum is `cfg_min_interval`, or 1 when that input is zero.
- R2: The timer counts cycles only in the idle state. The read request becomes valid exactly `cur_interval` clock edges after the block enters idle, counting from reset release or from the edge that completed the previous line.
- R3: The first line read after reset is address 0. Each finished line advances the address by one, and after NUM_LINES-1 (default 12 lines) the address wraps to 0.
- R4: Only one request is outstanding at a time. A read request and a scrub request are never valid together, and no new read is issued until the current line has finished. A valid request keeps its address stable until its ready is seen.
- R5: For a report with corrected count c ≤ E (default E = 8), a scrub request for the same line address follows exactly when c ≥ E − headroom. For c below that threshold no write request appears.
- R6: A report with c > E produces a one-cycle `fault_pulse` and sets `fault_sticky`, which stays set until reset. No scrub request is issued for that line, and the line changes neither the interval, the headroom nor the hard-error total.
- R7: With `cfg_gradual` high, a correctable report with c > E − headroom − G (default G = 1) halves `cur_interval`. The result is rounded down and clamped at the effective minimum. With `cfg_gradual` low, the corrected count never changes the interval.
- R8: With `cfg_adaptive` high, a correctable report whose hard count is at least E − HEADROOM − 1 (4 by default) sets `cur_headroom` to 0 from the next line onward. The line that triggers the drop is still judged with the old headroom. With `cfg_adaptive` low the headroom never changes.
- R9: The hard counts of correctable lines add up, saturating, into a running total. With `cfg_adaptive` high, the first report that brings the total above `cfg_hard_limit` halves the interval once, clamped at the minimum. This halving comes after any gradual halving on the same report. Later reports never trigger it again until reset.
- R10: `cur_interval` is never below `cfg_min_interval`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_interval | input | IV_W | Starting read interval in cycles, loaded at reset |
| cfg_min_interval | input | IV_W | Lowest interval the policies may reach |
| cfg_gradual | input | 1 | Enables the gradual rate-doubling policy |
| cfg_adaptive | input | 1 | Enables headroom removal and the hard-total rate step |
| cfg_hard_limit | input | HT_W | Hard-error total above which the adaptive rate step fires |
| rd_req_valid | output | 1 | Light-read request valid |
| rd_req_ready | input | 1 | Memory accepts the read request |
| rd_req_addr | output | AW | Line address to read |
| ecc_valid | input | 1 | ECC report for the outstanding read is present |
| ecc_corr | input | ERR_W | Corrected-error count of the line |
| ecc_hard | input | ERR_W | Hard-error count of the line |
| wr_req_valid | output | 1 | Scrub (rewrite) request valid |
| wr_req_ready | input | 1 | Write path accepts the scrub request |
| wr_req_addr | output | AW | Line address to rewrite |
| wr_done | input | 1 | Scrub write has completed |
| fault_pulse | output | 1 | One-cycle pulse for an uncorrectable line |
| fault_sticky | output | 1 | Set by any uncorrectable line, cleared by reset |
| cur_interval | output | IV_W | Read interval now in force |
| cur_headroom | output | ERR_W | Headroom now in force |

## Verification
The bench aims at the threshold edges. It sends a corrected count one below E − headroom and one exactly at it, which catches an off-by-one comparison that scrubs too early or never. It sends E and E + 1, which catches a design that rewrites an uncorrectable line or misses the fault. It walks past the last line to catch a wrap at a power of two instead of at the line count. It drives the interval down to its floor, where a design that forgets the clamp would stall the timer at zero or below the minimum. In adaptive mode, it checks that the headroom drop only affects the following line and that the hard-limit step fires once. A design that re-armed that step would keep halving the interval. The gap from idle to the next read is measured on every line, so a timer that counts during handshakes, or is off by one edge, shows up.

// File: rtl/drift_scrub_pkg.sv
package drift_scrub_pkg;

    localparam int DEF_ERR_W = 4;
    localparam int DEF_IV_W  = 16;
    localparam int DEF_HT_W  = 8;

    typedef enum logic [2:0] {
        SEQ_IDLE    = 3'd0,
        SEQ_RD_REQ  = 3'd1,
        SEQ_RD_WAIT = 3'd2,
        SEQ_WR_REQ  = 3'd3,
        SEQ_WR_WAIT = 3'd4
    } seq_state_e;

    typedef struct packed {
        logic fault;     // corrected count beyond the code strength
        logic scrub;     // line must be rewritten
        logic speed_up;  // gradual policy wants a faster read rate
    } line_verdict_t;

    function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

    function automatic int unsigned halve_floor(input int unsigned cur, input int unsigned floor_v);
        int unsigned half;
        half = cur >> 1;
        return (half < floor_v) ? floor_v : half;
    endfunction

endpackage

// File: rtl/drift_scrub_timer.sv
module drift_scrub_timer #(
    parameter int IV_W = drift_scrub_pkg::DEF_IV_W
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            en,
    input  logic [IV_W-1:0] limit,
    output logic            fire
);
    logic [IV_W-1:0] cnt_q;
    logic [IV_W:0]   cnt_inc;

    always_comb begin
        cnt_inc = {1'b0, cnt_q} + 1'b1;
        fire    = en && (cnt_inc >= {1'b0, limit});
    end

    always_ff @(posedge clk) begin
        if (rst || !en || fire) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_inc[IV_W-1:0];
        end
    end
endmodule

// File: rtl/drift_scrub_judge.sv
module drift_scrub_judge
    import drift_scrub_pkg::*;
#(
    parameter int ERR_W     = DEF_ERR_W,
    parameter int E_CORR    = 8,
    parameter int GRAD_STEP = 1
) (
    input  logic [ERR_W-1:0] corr,
    input  logic [ERR_W-1:0] headroom,
    input  logic             gradual_en,
    output line_verdict_t    verdict
);
    int c_i;
    int hr_i;

    always_comb begin
        c_i  = int'(corr);
        hr_i = int'(headroom);
        verdict.fault    = (c_i > E_CORR);
        verdict.scrub    = !verdict.fault && (c_i >= E_CORR - hr_i);
        verdict.speed_up = gradual_en && !verdict.fault
                           && (c_i > E_CORR - hr_i - GRAD_STEP);
    end
endmodule

// File: rtl/drift_scrub_policy.sv
module drift_scrub_policy
    import drift_scrub_pkg::*;
#(
    parameter int ERR_W    = DEF_ERR_W,
    parameter int IV_W     = DEF_IV_W,
    parameter int HT_W     = DEF_HT_W,
    parameter int E_CORR   = 8,
    parameter int HEADROOM = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IV_W-1:0]  cfg_interval,
    input  logic [IV_W-1:0]  cfg_min_interval,
    input  logic             cfg_adaptive,
    input  logic [HT_W-1:0]  cfg_hard_limit,
    input  logic             line_done,
    input  logic             speed_up,
    input  logic [ERR_W-1:0] hard_cnt,
    output logic [IV_W-1:0]  cur_interval,
    output logic [ERR_W-1:0] cur_headroom
);
    localparam int HARD_TRIG = (E_CORR - HEADROOM - 1 > 0) ? (E_CORR - HEADROOM - 1) : 0;

    logic [IV_W-1:0]  interval_q;
    logic [ERR_W-1:0] headroom_q;
    logic [HT_W-1:0]  total_q;
    logic             bumped_q;

    int unsigned      min_eff;
    int unsigned      ival_grad;
    int unsigned      ival_next;
    logic [HT_W:0]    total_sum;
    logic [HT_W-1:0]  total_next;
    logic             bump_now;
    logic             drop_now;

    always_comb begin
        min_eff    = (cfg_min_interval == '0) ? 32'd1 : 32'(cfg_min_interval);
        total_sum  = {1'b0, total_q} + (HT_W+1)'(hard_cnt);
        total_next = total_sum[HT_W] ? '1 : total_sum[HT_W-1:0];
        ival_grad  = speed_up ? halve_floor(32'(interval_q), min_eff) : 32'(interval_q);
        bump_now   = cfg_adaptive && !bumped_q && (total_next > cfg_hard_limit);
        ival_next  = bump_now ? halve_floor(ival_grad, min_eff) : ival_grad;
        drop_now   = cfg_adaptive && (32'(hard_cnt) >= HARD_TRIG);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            interval_q <= IV_W'(max_u(32'(cfg_interval), min_eff));
            headroom_q <= ERR_W'(HEADROOM);
            total_q    <= '0;
            bumped_q   <= 1'b0;
        end else if (line_done) begin
            interval_q <= IV_W'(ival_next);
            total_q    <= total_next;
            bumped_q   <= bumped_q | bump_now;
            if (drop_now) begin
                headroom_q <= '0;
            end
        end
    end

    assign cur_interval = interval_q;
    assign cur_headroom = headroom_q;
endmodule

// File: rtl/drift_scrub_scheduler.sv
module drift_scrub_scheduler
    import drift_scrub_pkg::*;
#(
    parameter int NUM_LINES = 12,
    parameter int E_CORR    = 8,
    parameter int HEADROOM  = 3,
    parameter int GRAD_STEP = 1,
    parameter int ERR_W     = DEF_ERR_W,
    parameter int IV_W      = DEF_IV_W,
    parameter int HT_W      = DEF_HT_W,
    localparam int AW       = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IV_W-1:0]  cfg_interval,
    input  logic [IV_W-1:0]  cfg_min_interval,
    input  logic             cfg_gradual,
    input  logic             cfg_adaptive,
    input  logic [HT_W-1:0]  cfg_hard_limit,
    output logic             rd_req_valid,
    input  logic             rd_req_ready,
    output logic [AW-1:0]    rd_req_addr,
    input  logic             ecc_valid,
    input  logic [ERR_W-1:0] ecc_corr,
    input  logic [ERR_W-1:0] ecc_hard,
    output logic             wr_req_valid,
    input  logic             wr_req_ready,
    output logic [AW-1:0]    wr_req_addr,
    input  logic             wr_done,
    output logic             fault_pulse,
    output logic             fault_sticky,
    output logic [IV_W-1:0]  cur_interval,
    output logic [ERR_W-1:0] cur_headroom
);
    localparam logic [AW-1:0] LAST_ADDR = AW'(NUM_LINES - 1);

    seq_state_e    state_q;
    logic [AW-1:0] addr_q;
    logic [AW-1:0] addr_next;
    logic          tick;
    logic          report_in;
    logic          line_done;
    line_verdict_t verdict;

    drift_scrub_timer #(.IV_W(IV_W)) u_timer (
        .clk   (clk),
        .rst   (rst),
        .en    (state_q == SEQ_IDLE),
        .limit (cur_interval),
        .fire  (tick)
    );

    drift_scrub_judge #(
        .ERR_W     (ERR_W),
        .E_CORR    (E_CORR),
        .GRAD_STEP (GRAD_STEP)
    ) u_judge (
        .corr       (ecc_corr),
        .headroom   (cur_headroom),
        .gradual_en (cfg_gradual),
        .verdict    (verdict)
    );

    assign report_in = (state_q == SEQ_RD_WAIT) && ecc_valid;
    assign line_done = report_in && !verdict.fault;

    drift_scrub_policy #(
        .ERR_W    (ERR_W),
        .IV_W     (IV_W),
        .HT_W     (HT_W),
        .E_CORR   (E_CORR),
        .HEADROOM (HEADROOM)
    ) u_policy (
        .clk              (clk),
        .rst              (rst),
        .cfg_interval     (cfg_interval),
        .cfg_min_interval (cfg_min_interval),
        .cfg_adaptive     (cfg_adaptive),
        .cfg_hard_limit   (cfg_hard_limit),
        .line_done        (line_done),
        .speed_up         (verdict.speed_up),
        .hard_cnt         (ecc_hard),
        .cur_interval     (cur_interval),
        .cur_headroom     (cur_headroom)
    );

    assign addr_next = (addr_q == LAST_ADDR) ? '0 : addr_q + 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q      <= SEQ_IDLE;
            addr_q       <= '0;
            fault_pulse  <= 1'b0;
            fault_sticky <= 1'b0;
        end else begin
            fault_pulse <= 1'b0;
            unique case (state_q)
                SEQ_IDLE: begin
                    if (tick) state_q <= SEQ_RD_REQ;
                end
                SEQ_RD_REQ: begin
                    if (rd_req_ready) state_q <= SEQ_RD_WAIT;
                end
                SEQ_RD_WAIT: begin
                    if (ecc_valid) begin
                        if (verdict.fault) begin
                            fault_pulse  <= 1'b1;
                            fault_sticky <= 1'b1;
                            state_q      <= SEQ_IDLE;
                            addr_q       <= addr_next;
                        end else if (verdict.scrub) begin
                            state_q <= SEQ_WR_REQ;
                        end else begin
                            state_q <= SEQ_IDLE;
                            addr_q  <= addr_next;
                        end
                    end
                end
                SEQ_WR_REQ: begin
                    if (wr_req_ready) state_q <= SEQ_WR_WAIT;
                end
                SEQ_WR_WAIT: begin
                    if (wr_done) begin
                        state_q <= SEQ_IDLE;
                        addr_q  <= addr_next;
                    end
                end
                default: state_q <= SEQ_IDLE;
            endcase
        end
    end

    assign rd_req_valid = (state_q == SEQ_RD_REQ);
    assign wr_req_valid = (state_q == SEQ_WR_REQ);
    assign rd_req_addr  = addr_q;
    assign wr_req_addr  = addr_q;
endmodule

// File: rtl/drift_scrub_scheduler_checks.sv
module drift_scrub_scheduler_checks #(
    parameter int NUM_LINES = 12,
    parameter int HEADROOM  = 3,
    parameter int ERR_W     = 4,
    parameter int IV_W      = 16,
    parameter int AW        = 4
) (
    input logic             clk,
    input logic             rst,
    input logic [IV_W-1:0]  cfg_min_interval,
    input logic             rd_req_valid,
    input logic             rd_req_ready,
    input logic [AW-1:0]    rd_req_addr,
    input logic             wr_req_valid,
    input logic             wr_req_ready,
    input logic [AW-1:0]    wr_req_addr,
    input logic             fault_pulse,
    input logic             fault_sticky,
    input logic [IV_W-1:0]  cur_interval,
    input logic [ERR_W-1:0] cur_headroom
);
    assert_single_request_R4: assert property (@(posedge clk) disable iff (rst)
        !(rd_req_valid && wr_req_valid));

    assert_read_held_R4: assert property (@(posedge clk) disable iff (rst)
        rd_req_valid && !rd_req_ready |=> rd_req_valid && $stable(rd_req_addr));

    assert_write_held_R4: assert property (@(posedge clk) disable iff (rst)
        wr_req_valid && !wr_req_ready |=> wr_req_valid && $stable(wr_req_addr));

    assert_addr_range_R3: assert property (@(posedge clk) disable iff (rst)
        32'(rd_req_addr) < NUM_LINES);

    assert_fault_no_scrub_R6: assert property (@(posedge clk) disable iff (rst)
        fault_pulse |-> fault_sticky && !wr_req_valid);

    assert_fault_sticky_R6: assert property (@(posedge clk) disable iff (rst)
        !$fell(fault_sticky));

    assert_headroom_values_R8: assert property (@(posedge clk) disable iff (rst)
        (32'(cur_headroom) == HEADROOM) || (cur_headroom == '0));

    assert_interval_floor_R10: assert property (@(posedge clk) disable iff (rst)
        cur_interval >= cfg_min_interval);
endmodule

bind drift_scrub_scheduler drift_scrub_scheduler_checks #(
    .NUM_LINES (NUM_LINES),
    .HEADROOM  (HEADROOM),
    .ERR_W     (ERR_W),
    .IV_W      (IV_W),
    .AW        (AW)
) u_checks (
    .clk              (clk),
    .rst              (rst),
    .cfg_min_interval (cfg_min_interval),
    .rd_req_valid     (rd_req_valid),
    .rd_req_ready     (rd_req_ready),
    .rd_req_addr      (rd_req_addr),
    .wr_req_valid     (wr_req_valid),
    .wr_req_ready     (wr_req_ready),
    .wr_req_addr      (wr_req_addr),
    .fault_pulse      (fault_pulse),
    .fault_sticky     (fault_sticky),
    .cur_interval     (cur_interval),
    .cur_headroom     (cur_headroom)
);

// File: tb/drift_scrub_scheduler_test.sv
`timescale 1ns/1ps
module drift_scrub_scheduler_test;
    localparam int LINES = 12;
    localparam int EC    = 8;
    localparam int HR    = 3;
    localparam int GS    = 1;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] cfg_interval = 16'd12;
    logic [15:0] cfg_min_interval = 16'd3;
    logic        cfg_gradual = 1'b0;
    logic        cfg_adaptive = 1'b0;
    logic [7:0]  cfg_hard_limit = 8'd20;
    logic        rd_req_valid;
    logic        rd_req_ready = 1'b0;
    logic [3:0]  rd_req_addr;
    logic        ecc_valid = 1'b0;
    logic [3:0]  ecc_corr = '0;
    logic [3:0]  ecc_hard = '0;
    logic        wr_req_valid;
    logic        wr_req_ready = 1'b0;
    logic [3:0]  wr_req_addr;
    logic        wr_done = 1'b0;
    logic        fault_pulse;
    logic        fault_sticky;
    logic [15:0] cur_interval;
    logic [3:0]  cur_headroom;

    int checks = 0;
    int errors = 0;

    int exp_addr, exp_int, exp_hr, exp_total, exp_min;
    bit exp_bumped, exp_sticky;

    always #2.5 clk = ~clk;

    drift_scrub_scheduler uut (
        .clk(clk), .rst(rst),
        .cfg_interval(cfg_interval), .cfg_min_interval(cfg_min_interval),
        .cfg_gradual(cfg_gradual), .cfg_adaptive(cfg_adaptive),
        .cfg_hard_limit(cfg_hard_limit),
        .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready), .rd_req_addr(rd_req_addr),
        .ecc_valid(ecc_valid), .ecc_corr(ecc_corr), .ecc_hard(ecc_hard),
        .wr_req_valid(wr_req_valid), .wr_req_ready(wr_req_ready), .wr_req_addr(wr_req_addr),
        .wr_done(wr_done), .fault_pulse(fault_pulse), .fault_sticky(fault_sticky),
        .cur_interval(cur_interval), .cur_headroom(cur_headroom)
    );

    task automatic check_eq(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int halve_to(input int v, input int m);
        int h = v / 2;
        return (h < m) ? m : h;
    endfunction

    task automatic do_reset(input int iv, input int mn, input bit g, input bit a, input int lim);
        @(negedge clk);
        rst = 1'b1;
        cfg_interval = 16'(iv);
        cfg_min_interval = 16'(mn);
        cfg_gradual = g;
        cfg_adaptive = a;
        cfg_hard_limit = 8'(lim);
        repeat (3) @(negedge clk);
        exp_min    = (mn == 0) ? 1 : mn;
        exp_int    = (iv > exp_min) ? iv : exp_min;
        exp_hr     = HR;
        exp_addr   = 0;
        exp_total  = 0;
        exp_bumped = 1'b0;
        exp_sticky = 1'b0;
        // R1: reset state
        check_eq("R1 rd_valid", int'(rd_req_valid), 0);
        check_eq("R1 wr_valid", int'(wr_req_valid), 0);
        check_eq("R1 fault", int'(fault_sticky) + int'(fault_pulse), 0);
        check_eq("R1 interval", int'(cur_interval), exp_int);
        check_eq("R1 headroom", int'(cur_headroom), exp_hr);
        rst = 1'b0;
    endtask

    // One complete line; called at the negedge right after the block entered idle.
    task automatic do_line(input int corr, input int hard, input int d1, input int d2);
        int gap = 0;
        bit fault, scrub, speed, bump;
        int tot;
        do begin
            @(negedge clk);
            gap++;
        end while (!rd_req_valid && gap < 100000);
        check_eq("R2 gap to read", gap, exp_int);
        check_eq("R3 read addr", int'(rd_req_addr), exp_addr);
        for (int i = 0; i < d1; i++) begin
            @(negedge clk);
            check_eq("R4 read held", int'(rd_req_valid), 1);
            check_eq("R4 read addr stable", int'(rd_req_addr), exp_addr);
        end
        rd_req_ready = 1'b1;
        @(negedge clk);
        rd_req_ready = 1'b0;
        for (int i = 0; i < d2; i++) @(negedge clk);
        check_eq("R4 nothing new while waiting", int'(rd_req_valid) + int'(wr_req_valid), 0);
        ecc_valid = 1'b1;
        ecc_corr  = 4'(corr);
        ecc_hard  = 4'(hard);
        @(negedge clk);
        ecc_valid = 1'b0;

        fault = (corr > EC);
        scrub = !fault && (corr >= EC - exp_hr);
        if (fault) begin
            exp_sticky = 1'b1;
        end else begin
            speed = cfg_gradual && (corr > EC - exp_hr - GS);
            tot = exp_total + hard;
            if (tot > 255) tot = 255;
            exp_total = tot;
            if (speed) exp_int = halve_to(exp_int, exp_min);
            bump = cfg_adaptive && !exp_bumped && (tot > int'(cfg_hard_limit));
            if (bump) begin
                exp_int = halve_to(exp_int, exp_min);
                exp_bumped = 1'b1;
            end
            if (cfg_adaptive && hard >= EC - HR - 1) exp_hr = 0;
        end
        check_eq("R6 fault pulse", int'(fault_pulse), int'(fault));
        check_eq("R6 fault sticky", int'(fault_sticky), int'(exp_sticky));
        check_eq("R5 scrub decision", int'(wr_req_valid), int'(scrub));
        check_eq("R7 R9 interval", int'(cur_interval), exp_int);
        check_eq("R8 headroom", int'(cur_headroom), exp_hr);
        check_eq("R10 floor", int'(cur_interval >= cfg_min_interval), 1);
        if (scrub) begin
            check_eq("R5 scrub addr", int'(wr_req_addr), exp_addr);
            for (int i = 0; i < d1; i++) @(negedge clk);
            check_eq("R4 write held", int'(wr_req_valid), 1);
            wr_req_ready = 1'b1;
            @(negedge clk);
            wr_req_ready = 1'b0;
            for (int i = 0; i < d2; i++) @(negedge clk);
            check_eq("R4 no read during scrub", int'(rd_req_valid), 0);
            wr_done = 1'b1;
            @(negedge clk);
            wr_done = 1'b0;
        end
        exp_addr = (exp_addr == LINES - 1) ? 0 : exp_addr + 1;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_0017));
        // Fixed headroom: thresholds, fault, wrap (R3, R5, R6)
        do_reset(12, 3, 1'b0, 1'b0, 20);
        do_line(0, 0, 0, 0);
        do_line(4, 0, 2, 1);   // R5 one below threshold 5
        do_line(5, 0, 0, 3);   // R5 exactly at threshold
        do_line(8, 0, 1, 0);   // R5 at E
        do_line(9, 0, 0, 0);   // R6 E+1
        for (int k = 0; k < 9; k++) do_line(k % 4, 1, 0, 0);  // R3 wrap past line 11
        check_eq("R6 sticky kept", int'(fault_sticky), 1);

        // Gradual halving down to the floor (R7, R10)
        do_reset(40, 3, 1'b1, 1'b0, 20);
        check_eq("R6 sticky cleared by reset", int'(fault_sticky), 0);
        do_line(5, 0, 0, 0);   // 40 -> 20
        do_line(4, 0, 0, 0);   // no change
        do_line(6, 0, 0, 0);   // 20 -> 10
        do_line(9, 0, 0, 0);   // fault: no change
        do_line(5, 0, 0, 0);   // 10 -> 5
        do_line(7, 0, 0, 0);   // 5 -> 3 floor
        do_line(5, 0, 0, 0);   // stays at 3

        // Adaptive headroom drop and one-time rate step (R8, R9)
        do_reset(32, 2, 1'b0, 1'b1, 6);
        do_line(0, 2, 0, 0);
        do_line(0, 2, 0, 0);
        do_line(0, 2, 0, 0);   // total 6, not above limit
        do_line(0, 2, 0, 0);   // total 8: 32 -> 16
        do_line(5, 4, 0, 0);   // scrub with old headroom, headroom -> 0
        do_line(5, 0, 0, 0);   // no scrub now
        do_line(7, 3, 0, 0);   // no scrub, no second step
        do_line(8, 0, 0, 0);   // scrub at E

        // Random mix
        for (int r = 0; r < 6; r++) begin
            do_reset(int'($urandom_range(40, 8)), int'($urandom_range(6, 0)),
                     1'($urandom_range(1, 0)), 1'($urandom_range(1, 0)),
                     int'($urandom_range(30, 5)));
            for (int n = 0; n < 15; n++) begin
                do_line(int'($urandom_range(10, 0)), int'($urandom_range(5, 0)),
                        int'($urandom_range(3, 0)), int'($urandom_range(3, 0)));
            end
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule